// File: doc/BRIEF.md
# Serial Peripheral Slave Receiver

This block receives bytes from an external SPI master. The serial clock, data and active-low select inputs are brought into the system clock domain through two-flop synchronizers. Clock edges are then found by comparing consecutive synchronized samples. While select is low, each sampling edge shifts one data bit into an internal register, most significant bit first. When a whole byte has arrived, it is copied into a holding register that the host reads through a plain data port.

A buffer-full flag and an interrupt line tell the host that a byte is waiting. A read strobe marks the byte as consumed. If another byte completes before the host has read the previous one, the newer byte replaces the held byte and a sticky overrun flag is raised. The host clears that flag by writing 1 to it. Two configuration inputs choose the idle clock level and the sampling edge. A status output mirrors the synchronized select line.

Top module: `spi_rx_slave`

## Requirements
- R1: Bits are assembled most significant bit first: the first bit sampled after select falls ends up in bit 7 of the received byte, and exactly 8 sampling edges complete a byte.
- R2: While `ssn_i` is high, serial clock edges neither complete a byte nor change the flags.
- R3: `ss_stat_o` is 1 while `ssn_i` is high and 0 while it is low, following the input two system clocks later.
- R4: `cpol_i` gives the idle clock level. With `cpha_i`=0, data is sampled on the edge leaving the idle level. With `cpha_i`=1, data is sampled on the edge returning to it. All four combinations work.
- R5: A completed byte appears on `rd_data_o` and sets `full_o` one clock after its last bit reaches the synchronized domain.
- R6: A one-cycle pulse on `rd_i` clears `full_o`. If a byte completes in the same cycle as the read, `full_o` stays set and no overrun is flagged.
- R7: A byte that completes while `full_o` is set, with no read in that cycle, sets `ovr_o`, and `rd_data_o` takes the newest byte.
- R8: A pulse on `clr_ovr_i` clears `ovr_o`. A new overrun in the same cycle wins over the clear.
- R9: `irq_o` is high whenever `full_o` or `ovr_o` is high.
- R10: A rise of `ssn_i` in the middle of a byte discards the bits received so far. The next byte starts from bit 7 again.
- R11: After reset, `full_o`=0, `ovr_o`=0, `rd_data_o`=0 and `ss_stat_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ssn_i | input | 1 | Slave select, active low |
| cpol_i | input | 1 | Idle clock level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| rd_i | input | 1 | Read strobe for the held byte |
| clr_ovr_i | input | 1 | Write-1 clear of the overrun flag |
| rd_data_o | output | 8 | Held received byte |
| full_o | output | 1 | Buffer holds an unread byte |
| ovr_o | output | 1 | Sticky overrun flag |
| ss_stat_o | output | 1 | Synchronized select status (1 = inactive) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit word and two synchronizer stages. It drives the serial clock at a half period of four system clocks, which leaves margin over the three-clock path from pin to buffer. With these settings, all four polarity/phase modes are reachable, as well as back-to-back bytes that overrun and a select that rises after four bits. A behavioural model sampling the same pins is compared with every output on every clock.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  parameter int unsigned SPI_WORD_DEF = 8;
  parameter int unsigned SPI_SYNC_DEF = 2;

  typedef struct packed {
    logic idle_hi;   // clock level between transfers
    logic late_smp;  // sample on the returning edge
  } spi_mode_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[LAST];

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("spi_rx_sync needs at least two stages");
    end
  endgenerate
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
  import spi_rx_pkg::*;
#(
  parameter int unsigned DW = SPI_WORD_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          ss_hi,
  input  spi_mode_t     mode,
  output logic          done_o,
  output logic [DW-1:0] byte_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic          sclk_p;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          flip, smp;

  // sampling edge is a rise of sclk ^ cpol ^ cpha
  assign flip = mode.idle_hi ^ mode.late_smp;
  assign smp  = (sclk_s ^ flip) & ~(sclk_p ^ flip) & ~ss_hi;
  assign byte_o = {sh_q[DW-2:0], mosi_s};

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_o = 1'b0;
    if (ss_hi) begin
      cnt_d = '0;
    end else if (smp) begin
      sh_d = {sh_q[DW-2:0], mosi_s};
      if (cnt_q == LAST_BIT) begin
        cnt_d  = '0;
        done_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sclk_p <= sclk_s;
      cnt_q  <= cnt_d;
      if (smp) sh_q <= sh_d;
    end
  end

  // R10: a deselect leaves the bit counter at zero
  assert_count_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_hi |=> cnt_q == '0);
  // R2: nothing completes while deselected
  assert_no_done_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_hi && $past(ss_hi)) |-> !done_o);
endmodule

// File: rtl/spi_rx_buf.sv
module spi_rx_buf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] byte_i,
  input  logic          rd_i,
  input  logic          clr_ovr_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o
);
  logic full_d, ovr_d, lost;

  assign lost = done_i & full_o & ~rd_i;

  always_comb begin
    full_d = full_o;
    if (done_i)    full_d = 1'b1;
    else if (rd_i) full_d = 1'b0;
    ovr_d = ovr_o;
    if (clr_ovr_i) ovr_d = 1'b0;
    if (lost)      ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (done_i) data_o <= byte_i;
      full_o <= full_d;
      ovr_o  <= ovr_d;
    end
  end

  assert_done_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> full_o && data_o == $past(byte_i));
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done_i) |=> !full_o);
  assert_ovr_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> $past(full_o) && $past(done_i));
  assert_clear_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr_i && !done_i) |=> !ovr_o);
endmodule

// File: rtl/spi_rx_slave.sv
module spi_rx_slave
  import spi_rx_pkg::*;
#(
  parameter int unsigned DW     = SPI_WORD_DEF,
  parameter int unsigned STAGES = SPI_SYNC_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          ssn_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          rd_i,
  input  logic          clr_ovr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          full_o,
  output logic          ovr_o,
  output logic          ss_stat_o,
  output logic          irq_o
);
  logic [2:0]    pins_s;
  logic          done;
  logic [DW-1:0] rx_byte;
  spi_mode_t     mode;

  assign mode = '{idle_hi: cpol_i, late_smp: cpha_i};

  // bit 2: select (resets to inactive), bit 1: data, bit 0: clock
  spi_rx_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ssn_i, mosi_i, sclk_i}), .q_o(pins_s)
  );

  spi_rx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .mosi_s(pins_s[1]), .ss_hi(pins_s[2]),
    .mode(mode), .done_o(done), .byte_o(rx_byte)
  );

  spi_rx_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .done_i(done), .byte_i(rx_byte), .rd_i(rd_i), .clr_ovr_i(clr_ovr_i),
    .data_o(rd_data_o), .full_o(full_o), .ovr_o(ovr_o)
  );

  assign ss_stat_o = pins_s[2];
  assign irq_o     = full_o | ovr_o;

  // R3: status follows the select pin with the synchronizer delay
  assert_ss_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ssn_i) && $past(ssn_i, 2)) |-> ss_stat_o);
  // R9: interrupt is never raised without a pending flag
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (full_o || ovr_o) && $past(done));
endmodule

// File: tb/spi_rx_slave_test.sv
`timescale 1ns/1ps
module spi_rx_slave_test;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ssn = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic rd = 1'b0, clr = 1'b0;
  logic [7:0] rd_data;
  logic full, ovr, ss_stat, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_rx_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .ssn_i(ssn),
    .cpol_i(cpol), .cpha_i(cpha), .rd_i(rd), .clr_ovr_i(clr),
    .rd_data_o(rd_data), .full_o(full), .ovr_o(ovr), .ss_stat_o(ss_stat), .irq_o(irq)
  );

  // behavioural reference: pin histories and integer bit count
  logic h1_ss, h2_ss, h3_ss, h1_ck, h2_ck, h3_ck, h1_d, h2_d, h3_d;
  logic [7:0] m_sh, m_data;
  int m_cnt;
  logic m_full, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {h1_ss, h2_ss, h3_ss} = 3'b111;
      {h1_ck, h2_ck, h3_ck} = 3'b000;
      {h1_d, h2_d, h3_d}    = 3'b000;
      m_sh = 8'h00; m_data = 8'h00; m_cnt = 0; m_full = 0; m_ovr = 0;
    end else begin
      logic inv, ev, fin;
      inv = cpol ^ cpha;
      ev  = ((h2_ck ^ inv) && !(h3_ck ^ inv)) && !h2_ss;
      fin = 0;
      if (h2_ss) m_cnt = 0;
      else if (ev) begin
        m_sh = {m_sh[6:0], h2_d};
        m_cnt++;
        if (m_cnt == 8) begin fin = 1; m_cnt = 0; end
      end
      if (clr) m_ovr = 0;
      if (fin) begin
        if (m_full && !rd) m_ovr = 1;
        m_data = m_sh;
        m_full = 1;
      end else if (rd) m_full = 0;
      h3_ss = h2_ss; h2_ss = h1_ss; h1_ss = ssn;
      h3_ck = h2_ck; h2_ck = h1_ck; h1_ck = sclk;
      h3_d  = h2_d;  h2_d  = h1_d;  h1_d  = mosi;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5 data model", rd_data, m_data);
      check("R5 full model", {7'd0, full}, {7'd0, m_full});
      check("R7 ovr model", {7'd0, ovr}, {7'd0, m_ovr});
      check("R3 ss model", {7'd0, ss_stat}, {7'd0, h2_ss});
      check("R9 irq model", {7'd0, irq}, {7'd0, m_full | m_ovr});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        mosi = b[i]; idle(HP);
        sclk = ~cpol; idle(HP);
        sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = b[i]; idle(HP);
        sclk = cpol; idle(HP);
      end
    end
    idle(HP + 2);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; idle(1); rd = 1'b0; idle(1);
  endtask

  task automatic set_mode(input logic p, input logic h);
    ssn = 1'b1; idle(4);
    cpol = p; cpha = h; sclk = p; idle(4);
    ssn = 1'b0; idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check("R11 data", rd_data, 8'h00);
    check("R11 full", {7'd0, full}, 8'h00);
    check("R11 ovr", {7'd0, ovr}, 8'h00);
    check("R11 ss_stat", {7'd0, ss_stat}, 8'h01);

    set_mode(1'b0, 1'b0);
    check("R3 ss low", {7'd0, ss_stat}, 8'h00);
    send_bits(8'hA5, 8);
    check("R1 R5 byte msb first", rd_data, 8'hA5);
    check("R5 full set", {7'd0, full}, 8'h01);
    check("R9 irq on full", {7'd0, irq}, 8'h01);
    pulse_rd();
    check("R6 read clears full", {7'd0, full}, 8'h00);

    // R4: the other three modes
    set_mode(1'b0, 1'b1); send_bits(8'h3C, 8);
    check("R4 mode 01", rd_data, 8'h3C); pulse_rd();
    set_mode(1'b1, 1'b0); send_bits(8'h81, 8);
    check("R4 mode 10", rd_data, 8'h81); pulse_rd();
    set_mode(1'b1, 1'b1); send_bits(8'h5A, 8);
    check("R4 mode 11", rd_data, 8'h5A); pulse_rd();

    // R7 overrun and R8 clear
    set_mode(1'b0, 1'b0);
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    check("R7 ovr set", {7'd0, ovr}, 8'h01);
    check("R7 newest kept", rd_data, 8'h22);
    clr = 1'b1; idle(1); clr = 1'b0; idle(1);
    check("R8 ovr cleared", {7'd0, ovr}, 8'h00);
    pulse_rd();
    check("R9 irq idle", {7'd0, irq}, 8'h00);

    // R2 clocks ignored while deselected
    ssn = 1'b1; idle(4);
    check("R3 ss high", {7'd0, ss_stat}, 8'h01);
    send_bits(8'hFF, 8);
    check("R2 no byte deselected", {7'd0, full}, 8'h00);
    check("R2 data unchanged", rd_data, 8'h22);

    // R10 abort mid-byte
    ssn = 1'b0; idle(4);
    send_bits(8'hF0, 4);
    ssn = 1'b1; idle(4);
    ssn = 1'b0; idle(4);
    send_bits(8'hC3, 8);
    check("R10 fresh byte after abort", rd_data, 8'hC3);
    check("R10 no overrun", {7'd0, ovr}, 8'h00);
    pulse_rd();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule